// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block arbitrates among 256 interrupt vectors for a single core. Sources post requests that carry a vector number and a trigger mode. The controller records each request in a pending set and the trigger mode in a trigger set. It selects the highest pending vector and offers that vector to the core only when the vector's priority class is above the current processor priority. The core takes an offered vector with an acknowledge. The acknowledge moves the vector from the pending set into the in-service set.

Software writes a task priority through an 8-bit port. The controller derives the processor priority from that task priority and from the highest vector in service. An end-of-interrupt pulse retires the highest in-service vector and reports, for one cycle, which vector was retired and whether it was level- or edge-triggered. Requests are taken only while both a hardware enable and a software enable are high.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the pending, in-service and trigger sets are empty, the task priority and `ppr_o` are 0, `irq_valid_o`, `req_accepted_o` and `eoi_done_o` are 0, and `irq_vector_o` and `eoi_vector_o` read 0.
- R2: `ppr_o` equals the full task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that in-service vector with bits [3:0] cleared. An empty in-service set counts as vector 0. `ppr_o` follows a task-priority write or an in-service change one cycle after the state that changed.
- R3: `irq_valid_o` is 1 exactly when the pending set is not empty and the highest pending vector, with bits [3:0] forced to 0, is strictly greater than the processor priority. The offer is registered from the state of the previous cycle. While no vector is offered, `irq_vector_o` reads 0.
- R4: The offered vector is the most significant set bit of the pending set.
- R5: `ack_i` takes effect only when an offer is valid and the offered vector is still pending. It then clears that pending bit and sets the matching in-service bit. Any other acknowledge is ignored.
- R6: An `eoi_i` with a non-empty in-service set clears the highest in-service bit. In the next cycle it pulses `eoi_done_o` with that vector on `eoi_vector_o` and the vector's trigger bit on `eoi_level_o` (1 = level, 0 = edge). The trigger bit is then cleared.
- R7: An `eoi_i` with an empty in-service set changes nothing and gives no `eoi_done_o` pulse.
- R8: A request is dropped, with no state change and no accepted pulse, unless both `hw_en_i` and `sw_en_i` are 1.
- R9: A level request (`req_level_i` = 1) for a vector that is already pending is discarded. An edge request for a pending vector keeps the vector pending and clears its trigger bit.
- R10: `req_accepted_o` pulses in the cycle after a request exactly when that request newly set a pending bit.
- R11: Within one cycle the updates are applied in a fixed order. The end-of-interrupt clear is applied before the acknowledge's in-service set. The acknowledge's pending clear and the end-of-interrupt's trigger clear are applied before a request's set. The "already pending" test uses the state from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en_i | input | 1 | Hardware enable for request intake |
| sw_en_i | input | 1 | Software enable for request intake |
| req_valid_i | input | 1 | Request strobe |
| req_vector_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accepted_o | output | 1 | Request newly set a pending bit (one cycle later) |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority write value |
| ppr_o | output | 8 | Processor priority |
| irq_valid_o | output | 1 | A vector is offered to the core |
| irq_vector_o | output | 8 | Offered vector |
| ack_i | input | 1 | Core acknowledges the offered vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_done_o | output | 1 | A vector was retired |
| eoi_vector_o | output | 8 | Retired vector |
| eoi_level_o | output | 1 | Trigger mode of the retired vector (1 = level) |

## Verification
The bench builds the controller with the default 8-bit vector width and 32-bit search words, so the search spans eight words. Stimulus therefore reaches word boundaries, the vectors below 16 that can never be offered, and the top class 0xF. Random vectors are biased toward a few values in different words. This makes duplicate level requests, edge re-requests of a pending vector, and acknowledge, end-of-interrupt and request for the same vector in one cycle occur often. Task-priority writes cover values on both sides of each pending class.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // trigger encoding shared by requests and end-of-interrupt reports
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // lowest bit of the priority class inside a vector
    localparam int CLASS_LSB = 4;
endpackage

// File: rtl/vic_find_msb.sv
module vic_find_msb #(
    parameter int N      = 256,
    parameter int WORD_W = 32
) (
    input  logic [N-1:0]         bits_i,
    output logic                 found_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int NW = N / WORD_W;
    localparam int WB = $clog2(WORD_W);
    localparam int IW = $clog2(N);

    function automatic logic [WB-1:0] word_msb(input logic [WORD_W-1:0] w);
        logic [WB-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (w[i]) r = WB'(i);
        end
        return r;
    endfunction

    logic [NW-1:0]    w_any;
    logic [NW*WB-1:0] w_idx;

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign w_any[g]           = |bits_i[g*WORD_W +: WORD_W];
        assign w_idx[g*WB +: WB]  = word_msb(bits_i[g*WORD_W +: WORD_W]);
    end

    always_comb begin
        found_o = |w_any;
        idx_o   = '0;
        for (int w = 0; w < NW; w++) begin
            if (w_any[w]) idx_o = (IW'(w) << WB) | IW'(w_idx[w*WB +: WB]);
        end
    end
endmodule

// File: rtl/vic_prio_calc.sv
module vic_prio_calc #(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_found_i,
    input  logic [VEC_W-1:0] isr_vec_i,
    output logic [VEC_W-1:0] ppr_o
);
    import vic_pkg::*;

    logic [VEC_W-1:0] isrv;

    always_comb begin
        isrv = isr_found_i ? isr_vec_i : '0;
        if (tpr_i[VEC_W-1:CLASS_LSB] >= isrv[VEC_W-1:CLASS_LSB])
            ppr_o = tpr_i;
        else
            ppr_o = {isrv[VEC_W-1:CLASS_LSB], {CLASS_LSB{1'b0}}};
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en_i,
    input  logic             sw_en_i,
    input  logic             req_valid_i,
    input  logic [VEC_W-1:0] req_vector_i,
    input  logic             req_level_i,
    output logic             req_accepted_o,
    input  logic             tpr_we_i,
    input  logic [VEC_W-1:0] tpr_wdata_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             irq_valid_o,
    output logic [VEC_W-1:0] irq_vector_o,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             eoi_done_o,
    output logic [VEC_W-1:0] eoi_vector_o,
    output logic             eoi_level_o
);
    import vic_pkg::*;

    localparam int NV = 1 << VEC_W;

    typedef struct packed {
        logic [NV-1:0]    irr;
        logic [NV-1:0]    isr;
        logic [NV-1:0]    tmr;
        logic [VEC_W-1:0] tpr;
        logic [VEC_W-1:0] ppr;
        logic             ov;
        logic [VEC_W-1:0] ovec;
        logic             acc;
        logic             edone;
        logic [VEC_W-1:0] evec;
        logic             elvl;
    } state_t;

    state_t st_q, st_d;

    logic             irr_found, isr_found;
    logic [VEC_W-1:0] irr_top, isr_top, ppr_calc;
    logic             ack_ok, req_ok, was_pending;

    vic_find_msb #(.N(NV), .WORD_W(WORD_W)) u_irr_msb (
        .bits_i(st_q.irr), .found_o(irr_found), .idx_o(irr_top)
    );

    vic_find_msb #(.N(NV), .WORD_W(WORD_W)) u_isr_msb (
        .bits_i(st_q.isr), .found_o(isr_found), .idx_o(isr_top)
    );

    vic_prio_calc #(.VEC_W(VEC_W)) u_prio (
        .tpr_i(st_q.tpr), .isr_found_i(isr_found), .isr_vec_i(isr_top), .ppr_o(ppr_calc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.acc   = 1'b0;
        st_d.edone = 1'b0;
        st_d.evec  = '0;
        st_d.elvl  = 1'b0;

        ack_ok      = ack_i && st_q.ov && st_q.irr[st_q.ovec];
        req_ok      = req_valid_i && hw_en_i && sw_en_i;
        was_pending = st_q.irr[req_vector_i];

        // retire first, so a same-cycle acknowledge can re-enter service
        if (eoi_i && isr_found) begin
            st_d.isr[isr_top] = 1'b0;
            st_d.elvl         = st_q.tmr[isr_top];
            st_d.tmr[isr_top] = 1'b0;
            st_d.edone        = 1'b1;
            st_d.evec         = isr_top;
        end

        if (ack_ok) begin
            st_d.irr[st_q.ovec] = 1'b0;
            st_d.isr[st_q.ovec] = 1'b1;
        end

        // request last: its set wins over same-cycle clears
        if (req_ok && !(was_pending && req_level_i == TRIG_LEVEL)) begin
            st_d.irr[req_vector_i] = 1'b1;
            st_d.tmr[req_vector_i] = req_level_i;
            st_d.acc               = !was_pending;
        end

        if (tpr_we_i) st_d.tpr = tpr_wdata_i;

        st_d.ppr  = ppr_calc;
        st_d.ov   = irr_found &&
                    ({irr_top[VEC_W-1:CLASS_LSB], {CLASS_LSB{1'b0}}} > st_q.ppr);
        st_d.ovec = st_d.ov ? irr_top : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_accepted_o = st_q.acc;
    assign ppr_o          = st_q.ppr;
    assign irq_valid_o    = st_q.ov;
    assign irq_vector_o   = st_q.ovec;
    assign eoi_done_o     = st_q.edone;
    assign eoi_vector_o   = st_q.evec;
    assign eoi_level_o    = st_q.elvl;

    // R3
    offer_above_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> ({irq_vector_o[VEC_W-1:CLASS_LSB], {CLASS_LSB{1'b0}}} > $past(ppr_o)));

    // R2
    ppr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr_o == $past(st_q.tpr)) || (ppr_o[CLASS_LSB-1:0] == '0));

    // R5
    ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_valid_o && st_q.irr[irq_vector_o] && !req_valid_i)
        |=> (st_q.isr[$past(irq_vector_o)] && !st_q.irr[$past(irq_vector_o)]));

    // R7
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && st_q.isr == '0) |=> !eoi_done_o);

    // R9
    level_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_level_i && st_q.irr[req_vector_i]) |=> !req_accepted_o);

    // R8
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !(hw_en_i && sw_en_i)) |=> !req_accepted_o);
endmodule

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en, sw_en, req_valid, req_level, tpr_we, ack, eoi;
    logic [7:0] req_vector, tpr_wdata;
    logic       req_accepted, irq_valid, eoi_done, eoi_level;
    logic [7:0] ppr, irq_vector, eoi_vector;

    int n_chk = 0;
    int n_bad = 0;

    always #5ns clk = ~clk;

    vic_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hw_en_i(hw_en), .sw_en_i(sw_en),
        .req_valid_i(req_valid), .req_vector_i(req_vector), .req_level_i(req_level),
        .req_accepted_o(req_accepted), .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata),
        .ppr_o(ppr), .irq_valid_o(irq_valid), .irq_vector_o(irq_vector),
        .ack_i(ack), .eoi_i(eoi), .eoi_done_o(eoi_done),
        .eoi_vector_o(eoi_vector), .eoi_level_o(eoi_level)
    );

    // reference state, holds the values expected after the latest edge
    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    logic [7:0]   m_tpr = '0, m_ppr = '0, m_ovec = '0, m_evec = '0;
    logic         m_ov = 1'b0, m_acc = 1'b0, m_edone = 1'b0, m_elvl = 1'b0;

    function automatic logic [8:0] top_bit(input logic [255:0] b);
        logic [8:0] r;
        r = '0;
        for (int i = 0; i < 256; i++) if (b[i]) r = {1'b1, 8'(i)};
        return r;
    endfunction

    function automatic logic [7:0] prio(input logic [7:0] t, input logic [255:0] s);
        logic [8:0] h;
        logic [7:0] v;
        h = top_bit(s);
        v = h[8] ? h[7:0] : 8'h00;
        return (t[7:4] >= v[7:4]) ? t : {v[7:4], 4'h0};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [255:0] ni, ns, nt;
        logic [8:0]   hi, hp;
        logic         was;
        ni = m_irr; ns = m_isr; nt = m_tmr;
        hi = top_bit(m_isr);
        hp = top_bit(m_irr);
        m_edone = 1'b0; m_evec = '0; m_elvl = 1'b0; m_acc = 1'b0;
        if (eoi && hi[8]) begin
            ns[hi[7:0]] = 1'b0; m_elvl = m_tmr[hi[7:0]]; nt[hi[7:0]] = 1'b0;
            m_edone = 1'b1; m_evec = hi[7:0];
        end
        if (ack && m_ov && m_irr[m_ovec]) begin
            ni[m_ovec] = 1'b0; ns[m_ovec] = 1'b1;
        end
        if (req_valid && hw_en && sw_en) begin
            was = m_irr[req_vector];
            if (!(was && req_level)) begin
                ni[req_vector] = 1'b1; nt[req_vector] = req_level; m_acc = !was;
            end
        end
        m_ov   = hp[8] && ({hp[7:4], 4'h0} > m_ppr);
        m_ovec = m_ov ? hp[7:0] : 8'h00;
        m_ppr  = prio(m_tpr, m_isr);
        if (tpr_we) m_tpr = tpr_wdata;
        m_irr = ni; m_isr = ns; m_tmr = nt;
    endtask

    task automatic compare_all();
        chk("R3 irq_valid", irq_valid, m_ov);
        chk("R4 irq_vector", irq_vector, m_ovec);
        chk("R2 ppr", ppr, m_ppr);
        chk("R10 accepted", req_accepted, m_acc);
        chk("R6 eoi_done", eoi_done, m_edone);
        chk("R6 eoi_vector", eoi_vector, m_evec);
        chk("R6 eoi_level", eoi_level, m_elvl);
    endtask

    // drive at the falling edge, compare at the following falling edge
    task automatic step(input logic r, input logic [7:0] v, input logic l,
                        input logic a, input logic e, input logic tw,
                        input logic [7:0] td, input logic h, input logic s);
        req_valid = r; req_vector = v; req_level = l; ack = a; eoi = e;
        tpr_we = tw; tpr_wdata = td; hw_en = h; sw_en = s;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 0, 0, 0, 8'h00, 1, 1);
    endtask

    initial begin
        #2ms;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        logic [7:0] pool [6];
        seed_init = $urandom(32'h5EED);
        pool[0] = 8'h31; pool[1] = 8'h52; pool[2] = 8'h57;
        pool[3] = 8'h80; pool[4] = 8'hA3; pool[5] = 8'h0F;
        req_valid = 0; req_vector = 0; req_level = 0; ack = 0; eoi = 0;
        tpr_we = 0; tpr_wdata = 0; hw_en = 1; sw_en = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq_valid", irq_valid, 0);
        chk("R1 ppr", ppr, 0);
        chk("R1 eoi_done", eoi_done, 0);
        chk("R1 accepted", req_accepted, 0);
        chk("R1 irq_vector", irq_vector, 0);
        rst_n = 1'b1;
        @(negedge clk);

        step(1, 8'h45, 0, 0, 0, 0, 0, 1, 1);
        chk("R10 new edge request", req_accepted, 1);
        idle();
        chk("R4 offer 0x45", irq_vector, 8'h45);
        step(1, 8'h45, 1, 0, 0, 0, 0, 1, 1);
        chk("R9 level duplicate", req_accepted, 0);
        step(1, 8'h92, 0, 0, 0, 0, 0, 1, 1);
        idle();
        chk("R4 highest wins", irq_vector, 8'h92);
        step(0, 0, 0, 0, 0, 1, 8'h95, 1, 1);
        idle(); idle();
        chk("R2 ppr from tpr", ppr, 8'h95);
        chk("R3 masked by tpr", irq_valid, 0);
        step(0, 0, 0, 0, 0, 1, 8'h00, 1, 1);
        idle(); idle();
        chk("R3 unmasked", irq_valid, 1);
        step(0, 0, 0, 1, 0, 0, 0, 1, 1);
        idle(); idle();
        chk("R5 R2 ppr from in-service", ppr, 8'h90);
        chk("R3 lower class held off", irq_valid, 0);
        step(0, 0, 0, 0, 1, 0, 0, 1, 1);
        chk("R6 retire", eoi_done, 1);
        chk("R6 retire vector", eoi_vector, 8'h92);
        chk("R6 edge report", eoi_level, 0);
        idle(); idle();
        chk("R6 next offer", irq_vector, 8'h45);
        step(0, 0, 0, 0, 1, 0, 0, 1, 1);
        chk("R7 empty eoi", eoi_done, 0);
        step(1, 8'h60, 0, 0, 0, 0, 0, 1, 0);
        chk("R8 sw disable", req_accepted, 0);
        step(1, 8'h61, 0, 0, 0, 0, 0, 0, 1);
        chk("R8 hw disable", req_accepted, 0);
        idle();
        chk("R8 nothing pending added", irq_vector, 8'h45);
        step(1, 8'hB0, 1, 0, 0, 0, 0, 1, 1);
        chk("R10 level new", req_accepted, 1);
        idle();
        step(0, 0, 0, 1, 0, 0, 0, 1, 1);
        idle();
        step(0, 0, 0, 0, 1, 0, 0, 1, 1);
        chk("R6 level report", eoi_level, 1);
        chk("R6 level vector", eoi_vector, 8'hB0);
        idle(); idle(); idle();
        step(1, 8'h45, 0, 1, 0, 0, 0, 1, 1);
        idle(); idle();
        chk("R11 in service blocks", irq_valid, 0);
        step(0, 0, 0, 0, 1, 0, 0, 1, 1);
        idle(); idle();
        chk("R11 request survived ack", irq_vector, 8'h45);
        step(0, 0, 0, 1, 0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 0, 0, 0, 1, 1);
        idle();
        chk("R5 stale ack ignored", irq_valid, 0);

        for (int n = 0; n < 4000; n++) begin
            logic [7:0] v;
            v = ($urandom % 2) ? pool[$urandom % 6] : 8'($urandom);
            step(($urandom % 4) != 0, v, ($urandom % 3) == 0,
                 ($urandom % 2) == 0, ($urandom % 5) == 0,
                 ($urandom % 16) == 0, 8'($urandom),
                 ($urandom % 20) != 0, ($urandom % 20) != 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule